// File: doc/BRIEF.md
# Asynchronous SRAM bus cycle generator

This block sits between a clocked host and a byte-wide asynchronous static memory. The host offers one read or write at a time on a valid/ready handshake. The block turns each accepted request into a full memory bus cycle. It drives the address, the active-low chip enable, output enable and write enable, and an 8-bit write-data bus with its own drive enable. Every timing minimum of the memory is held for a whole number of clock cycles. Each such count is derived at elaboration as the ceiling of a nanosecond figure divided by the clock period.

A read asserts chip enable and output enable together. It holds them until both the address access time and the output-enable access time have elapsed, and captures the data bus in the last cycle of that window. It then releases the enables and waits out the memory's output turn-off time before it reports completion. A write keeps output enable high throughout. It pulls chip enable and write enable low for a pulse that covers both the minimum strobe width and the data setup time, with the data already driven. After write enable rises, the block keeps driving the data for the hold time, and longer if the minimum write cycle time needs it. The address is latched at acceptance and does not change until the next acceptance. A one-cycle done pulse marks the return to idle, and read data is presented with it.

Top module: `sram_cycle_gen`

## Requirements
- R1: During and right after reset, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, done is 0 and req_ready is 1.
- R2: req_ready is 1 only while idle. A request is taken only on a clock edge where req_valid and req_ready are both 1. req_valid held high while busy starts no extra cycle and does not change the address or data of the cycle in flight.
- R3: A read holds mem_ce_n and mem_oe_n both at 0 for exactly RD = max(ceil(70/T), ceil(35/T)) cycles, where T is the clock period in ns (18 at T = 4). mem_we_n stays 1. rd_data is the bus value sampled in the last cycle of that window.
- R4: After the read window, both enables stay high for RL = max(ceil(25/T), ceil(70/T) - RD, 1) cycles (7 at T = 4) before done. A read therefore spans RD + RL cycles from acceptance to done.
- R5: A write keeps mem_oe_n at 1 throughout. It holds mem_ce_n and mem_we_n both at 0 for exactly WS = max(ceil(50/T), ceil(30/T)) cycles (13 at T = 4), with mem_dq_oe at 1 and mem_dq_out equal to the request data.
- R6: After mem_we_n rises, mem_dq_oe stays 1 with unchanged data for WH = max(ceil(5/T), ceil(70/T) - WS, 1) cycles (5 at T = 4). mem_dq_oe then falls, and the write spans WS + WH cycles from acceptance to done.
- R7: mem_addr equals the accepted request address in every cycle in which any enable is 0 or mem_dq_oe is 1.
- R8: mem_dq_oe is never 1 while mem_oe_n is 0. After a read, mem_dq_oe rises only once mem_oe_n has been 1 for at least ceil(25/T) cycles.
- R9: done is 1 for exactly one cycle, in the first idle cycle after each cycle ends. req_ready is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Request address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read data, valid with done after a read |
| mem_addr | output | 11 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data bus as seen from the memory |

## Verification
A phase entered too early or a timer loaded with the wrong length shows up at the ports within a single transaction. An enable window is one cycle short or long. Read data is captured before the modelled memory turns valid and so arrives inverted. Or done arrives a cycle off the expected span. A state machine that strays into the wrong phase shows on the same or next cycle as output enable low during a write, data driven against a read, or an address that moves under an active enable. Every address is written and read back, so a datapath fault appears as a wrong byte at the first affected address.

// File: rtl/sram_cyc_pkg.sv
// Shared types and elaboration-time helpers for the SRAM cycle generator.
// Assumes all timing figures are given as whole nanoseconds.
package sram_cyc_pkg;

    // Bus phases; each non-idle phase lasts a fixed number of cycles.
    typedef enum logic [2:0] {
        PH_IDLE       = 3'd0,
        PH_RD_ACCESS  = 3'd1,
        PH_RD_RELEASE = 3'd2,
        PH_WR_STROBE  = 3'd3,
        PH_WR_HOLD    = 3'd4
    } phase_t;

    // Rounds a nanosecond figure up to whole clock cycles.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Phase timer: loadable down counter that flags its final cycle.
// Assumes the sequencer loads (length - 1) on the edge that enters a phase
// and leaves the phase on the edge where 'expired' is high.
module sram_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Last cycle of the running phase.
    assign expired = (count_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Bus sequencer: walks idle -> read access -> read release -> idle, or
// idle -> write strobe -> write hold -> idle. Phase lengths are parameters
// in clock cycles, all at least 1. Requests are taken only in idle.
module sram_seq_fsm
    import sram_cyc_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int RD_LEN = 18,
    parameter int RL_LEN = 7,
    parameter int WS_LEN = 13,
    parameter int WH_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output phase_t           phase,
    output logic             req_ready,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             capture,
    output logic             done
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] RL_LOAD = CNT_W'(RL_LEN - 1);
    localparam logic [CNT_W-1:0] WS_LOAD = CNT_W'(WS_LEN - 1);
    localparam logic [CNT_W-1:0] WH_LOAD = CNT_W'(WH_LEN - 1);

    phase_t phase_q;
    phase_t phase_d;
    logic   finish;
    logic   done_q;

    // Next phase, timer load and datapath strobes for the current phase.
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (req_write) begin
                        phase_d  = PH_WR_STROBE;
                        load_val = WS_LOAD;
                    end else begin
                        phase_d  = PH_RD_ACCESS;
                        load_val = RD_LOAD;
                    end
                end
            end
            PH_RD_ACCESS: begin
                if (expired) begin
                    capture  = 1'b1;
                    load     = 1'b1;
                    load_val = RL_LOAD;
                    phase_d  = PH_RD_RELEASE;
                end
            end
            PH_RD_RELEASE: begin
                if (expired) begin
                    finish  = 1'b1;
                    phase_d = PH_IDLE;
                end
            end
            PH_WR_STROBE: begin
                if (expired) begin
                    load     = 1'b1;
                    load_val = WH_LOAD;
                    phase_d  = PH_WR_HOLD;
                end
            end
            PH_WR_HOLD: begin
                if (expired) begin
                    finish  = 1'b1;
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Completion pulse, high in the first idle cycle after a bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    assign phase     = phase_q;
    assign req_ready = (phase_q == PH_IDLE);
    assign done      = done_q;

endmodule

// File: rtl/sram_bus_datapath.sv
// Datapath: latches address and write data on acceptance and captures read
// data on the sequencer's capture strobe. Assumes accept only in idle, so
// the address never moves while the memory is enabled.
module sram_bus_datapath #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Request address and write data, held for the whole bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read data sampled at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= mem_dq_in;
        end
    end

endmodule

// File: rtl/sram_cycle_gen.sv
// Asynchronous SRAM bus cycle generator (top).
// Converts single valid/ready requests into timed memory read or write
// cycles. Nanosecond minimums are turned into cycle counts at elaboration
// for the clock period CLK_NS. Control outputs are decoded from the phase
// register only, so they change once per cycle just after the clock edge.
module sram_cycle_gen
    import sram_cyc_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 4,
    parameter int T_RC_NS  = 70,
    parameter int T_AA_NS  = 70,
    parameter int T_OA_NS  = 35,
    parameter int T_HZ_NS  = 25,
    parameter int T_WC_NS  = 70,
    parameter int T_WP_NS  = 50,
    parameter int T_DS_NS  = 30,
    parameter int T_DH_NS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int RC_CYC  = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int AA_CYC  = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int OA_CYC  = ns_to_cycles(T_OA_NS, CLK_NS);
    localparam int HZ_CYC  = ns_to_cycles(T_HZ_NS, CLK_NS);
    localparam int WC_CYC  = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int WP_CYC  = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int DS_CYC  = ns_to_cycles(T_DS_NS, CLK_NS);
    localparam int DH_CYC  = ns_to_cycles(T_DH_NS, CLK_NS);

    localparam int RD_LEN  = imax(imax(AA_CYC, OA_CYC), 1);
    localparam int RL_LEN  = imax(imax(HZ_CYC, RC_CYC - RD_LEN), 1);
    localparam int WS_LEN  = imax(imax(WP_CYC, DS_CYC), 1);
    localparam int WH_LEN  = imax(imax(DH_CYC, WC_CYC - WS_LEN), 1);
    localparam int MAX_LEN = imax(imax(RD_LEN, RL_LEN), imax(WS_LEN, WH_LEN));
    localparam int CNT_W   = imax($clog2(MAX_LEN), 1);

    phase_t           phase;
    logic             expired;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             accept;
    logic             capture;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .RD_LEN (RD_LEN),
        .RL_LEN (RL_LEN),
        .WS_LEN (WS_LEN),
        .WH_LEN (WH_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .phase     (phase),
        .req_ready (req_ready),
        .load      (load),
        .load_val  (load_val),
        .accept    (accept),
        .capture   (capture),
        .done      (done)
    );

    sram_bus_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rd_data)
    );

    // Memory control strobes decoded from the current phase.
    always_comb begin
        mem_ce_n  = !((phase == PH_RD_ACCESS) || (phase == PH_WR_STROBE));
        mem_oe_n  = !(phase == PH_RD_ACCESS);
        mem_we_n  = !(phase == PH_WR_STROBE);
        mem_dq_oe = (phase == PH_WR_STROBE) || (phase == PH_WR_HOLD);
    end

endmodule

// File: rtl/sram_cycle_gen_chk.sv
// Protocol checker for sram_cycle_gen, attached by bind. Watches only the
// top-level ports and counts enable run lengths itself.
module sram_cycle_gen_chk #(
    parameter int ADDR_W = 11,
    parameter int RD_LEN = 18,
    parameter int WS_LEN = 13,
    parameter int HZ_CYC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    int we_lo_cnt;
    int oe_lo_cnt;
    int oe_hi_cnt;

    // Run lengths of write-enable low, output-enable low and output-enable high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_cnt <= 0;
            oe_lo_cnt <= 0;
            oe_hi_cnt <= HZ_CYC;
        end else begin
            we_lo_cnt <= mem_we_n ? 0 : we_lo_cnt + 1;
            oe_lo_cnt <= mem_oe_n ? 0 : oe_lo_cnt + 1;
            if (!mem_oe_n)
                oe_hi_cnt <= 0;
            else if (oe_hi_cnt < HZ_CYC)
                oe_hi_cnt <= oe_hi_cnt + 1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done && req_ready));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n || mem_dq_oe) |-> !req_ready);

    assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_lo_cnt == RD_LEN));

    assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == WS_LEN));

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(!mem_ce_n) || $past(mem_dq_oe)) && (!mem_ce_n || mem_dq_oe))
            |-> $stable(mem_addr));

    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= HZ_CYC));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

endmodule

bind sram_cycle_gen sram_cycle_gen_chk #(
    .ADDR_W (ADDR_W),
    .RD_LEN (RD_LEN),
    .WS_LEN (WS_LEN),
    .HZ_CYC (HZ_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_cycle_gen_tb.sv
// Bench: behavioural memory model plus a full write-then-read sweep of every
// address, with cycle counts computed here from the nanosecond minimums.
module sram_cycle_gen_tb;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int T  = 4;
    localparam int DEPTH = 1 << AW;

    function automatic int cdiv(input int ns);
        return (ns + T - 1) / T;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD = mx(cdiv(70), cdiv(35));
    localparam int E_RL = mx(mx(cdiv(25), cdiv(70) - E_RD), 1);
    localparam int E_WS = mx(cdiv(50), cdiv(30));
    localparam int E_WH = mx(mx(cdiv(5), cdiv(70) - E_WS), 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] shadow [DEPTH];
    int            acc_cnt = 0;
    logic          we_prev = 1'b1;

    always #(T / 2) clk = ~clk;

    sram_cycle_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: data valid once the read enables have been low long enough,
    // inverted garbage before that; writes commit when write enable rises.
    always @(negedge clk) begin
        acc_cnt <= (!mem_ce_n && !mem_oe_n) ? acc_cnt + 1 : 0;
        we_prev <= mem_we_n;
        if (!we_prev && mem_we_n && mem_dq_oe)
            model[mem_addr] <= mem_dq_out;
    end
    assign mem_dq_in = (acc_cnt >= mx(cdiv(70), cdiv(35))) ? model[mem_addr]
                                                          : ~model[mem_addr];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 37 + (a >> 5)) ^ 8'h5A;
    endfunction

    // One complete transaction with per-cycle port observation.
    task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int ce_lo = 0, oe_lo = 0, we_lo = 0, dq_cnt = 0, total = 0;
        int addr_bad = 0, cont_bad = 0, data_bad = 0, guard = 0;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R9", "ready idle after done", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        chk(req_ready == 1'b0, "R2", "ready low while busy", int'(req_ready), 0);
        while (!done && guard < 200) begin
            if (!mem_ce_n) ce_lo++;
            if (!mem_oe_n) oe_lo++;
            if (!mem_we_n) we_lo++;
            if (mem_dq_oe) dq_cnt++;
            if ((!mem_ce_n || mem_dq_oe) && mem_addr != a) addr_bad++;
            if (mem_dq_oe && !mem_oe_n) cont_bad++;
            if (mem_dq_oe && mem_dq_out != d) data_bad++;
            total++; guard++;
            @(negedge clk);
        end
        chk(guard < 200, "R9", "done arrived", guard, total);
        chk(req_ready == 1'b1, "R9", "ready with done", int'(req_ready), 1);
        chk(addr_bad == 0, "R7", "address moved", addr_bad, 0);
        chk(cont_bad == 0, "R8", "drive with oe low", cont_bad, 0);
        if (wr) begin
            chk(oe_lo == 0, "R5", "oe low in write", oe_lo, 0);
            chk(we_lo == E_WS && ce_lo == E_WS, "R5", "strobe width", we_lo, E_WS);
            chk(data_bad == 0, "R6", "write data", data_bad, 0);
            chk(dq_cnt == E_WS + E_WH, "R6", "drive span", dq_cnt, E_WS + E_WH);
            chk(total == E_WS + E_WH, "R6", "write span", total, E_WS + E_WH);
            shadow[a] = d;
        end else begin
            chk(ce_lo == E_RD && oe_lo == E_RD, "R3", "read window", oe_lo, E_RD);
            chk(we_lo == 0 && dq_cnt == 0, "R3", "no write in read", we_lo + dq_cnt, 0);
            chk(rd_data == shadow[a], "R3", "read data", int'(rd_data), int'(shadow[a]));
            chk(total == E_RD + E_RL, "R4", "read span", total, E_RD + E_RL);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            model[i]  = DW'(i * 3 + 1);
            shadow[i] = DW'(i * 3 + 1);
        end
        repeat (4) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done && req_ready,
            "R1", "outputs in reset", int'(mem_dq_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done && req_ready,
            "R1", "outputs after reset", int'(mem_ce_n), 1);

        // Reads of the initial contents, then a read-to-write turnaround (R8).
        run_txn(1'b0, 11'h000, 8'h00);
        run_txn(1'b0, 11'h7FF, 8'h00);
        run_txn(1'b1, 11'h7FF, 8'hA5);
        run_txn(1'b0, 11'h7FF, 8'h00);

        // Full write sweep then full read-back sweep.
        for (int a = 0; a < DEPTH; a++) run_txn(1'b1, AW'(a), pat(a));
        for (int a = 0; a < DEPTH; a++) run_txn(1'b0, AW'(a), 8'h00);

        // R2: valid held through a busy write with changed address and data.
        begin
            int dones = 0;
            int guard = 0;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h123; req_wdata = 8'h3C;
            @(negedge clk);
            req_addr = 11'h456; req_wdata = 8'hC3;
            repeat (5) begin
                chk(req_ready == 1'b0, "R2", "ready while held", int'(req_ready), 0);
                @(negedge clk);
            end
            req_valid = 1'b0;
            while (!done && guard < 200) begin guard++; @(negedge clk); end
            if (done) dones++;
            @(negedge clk);
            chk(done == 1'b0 && dones == 1, "R2", "single cycle from held valid", dones, 1);
            shadow[11'h123] = 8'h3C;
        end
        run_txn(1'b0, 11'h123, 8'h00);
        run_txn(1'b0, 11'h456, 8'h00);

        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule